// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a core's store pipeline and its data cache. It gives the core total-store ordering. A store goes straight into an in-order queue of eight entries without any cache lookup. It is reported retired in the same cycle it is accepted. The queue then hands its stores to the cache one at a time, oldest first. Each store waits for the cache to acknowledge its write before the next one is offered. Because the queued stores are not yet globally visible, they must still be seen by later loads of the same core.

Every load is compared against all occupied entries at once. An entry is a candidate when its word address equals the load's and it writes at least one byte the load asks for. Among the candidates the youngest one decides the result. If that store wrote every requested byte, its data is returned with a hit flag. This happens whether or not the cache holds the line. If it wrote only some of the requested bytes, the load is told to replay. When no entry is a candidate, the load proceeds to the cache.

The write side is governed by a two-state machine:
- `DR_IDLE`: no request is shown to the cache.
- `DR_BUSY`: a request for the head entry is held on the write port.

There are two transitions:
- `LAUNCH`: `DR_IDLE` to `DR_BUSY`, taken when the queue holds at least one entry.
- `RETIRE`: `DR_BUSY` to `DR_IDLE`, taken when the cache acknowledges; the head entry is removed on that edge.

The machine always passes through `DR_IDLE` for one cycle after each write.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `full`=0, `st_ready`=1, `wr_req`=0, and a load gets `ld_hit`=0 and `ld_replay`=0.
- R2: A store presented with `st_valid`=1 while not full is accepted on that clock edge. `st_retired` is 1 in that same cycle, with no dependence on the cache.
- R3: Stores are offered to the cache strictly in enqueue order, and `wr_addr`/`wr_data`/`wr_be` always show the oldest entry.
- R4: Only one write is outstanding. `wr_req` and its address, data and enables stay unchanged until `wr_ack`. The head entry is removed on the acknowledged edge. `wr_req` is low for the cycle after an acknowledge. `wr_ack` while `wr_req` is low has no effect.
- R5: A load compares against every occupied entry. The candidates are entries with an equal word address and at least one common enabled byte. The youngest candidate is selected.
- R6: If the selected entry's byte enables include every byte in `ld_be`, then `ld_hit`=1. `ld_data` then holds that entry's data with the unrequested bytes zero. Byte i is bits 8i+7..8i, enabled by bit i.
- R7: If the selected entry lacks any requested byte, then `ld_replay`=1 and `ld_hit`=0.
- R8: With no candidate, `ld_hit`=0, `ld_replay`=0 and `ld_data`=0. A store accepted in the same cycle as a load is not visible to that load.
- R9: With 8 entries, `full`=1 and `st_ready`=0. A store is then refused (`st_retired`=0) even if the cache acknowledges in that cycle, and it leaves no entry behind.
- R10: An enqueue and an acknowledged drain in the same cycle both take effect, and the occupancy stays consistent.
- R11: The entry whose write is outstanding remains forwardable until its acknowledge, and not after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store enqueue request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_ready | output | 1 | Buffer can accept a store |
| st_retired | output | 1 | Store accepted and retired this cycle |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Load byte enables |
| ld_hit | output | 1 | Load fully served from the buffer |
| ld_replay | output | 1 | Partial overlap, load must replay |
| ld_data | output | DW | Forwarded data, requested bytes only |
| full | output | 1 | All entries occupied |
| wr_req | output | 1 | Write request to the cache |
| wr_addr | output | AW | Address of the head entry |
| wr_data | output | DW | Data of the head entry |
| wr_be | output | DW/8 | Byte enables of the head entry |
| wr_ack | input | 1 | Cache accepted the write |

## Verification
The bench targets these corner cases:
- **Several stores to one word.** A design that chose the oldest match would return stale data.
- **Disjoint byte masks at one address.** A design that ignored byte overlap would select the wrong entry or replay needlessly.
- **Partial coverage.** A design that skipped the replay check would forward incomplete data.
- **Store and load in the same cycle.** A leaky design would forward from the store being enqueued.
- **A store offered while full, together with an acknowledge.** A lax design would accept the store or lose an entry.
- **Enqueue and drain in the same cycle.** A design with wrong occupancy arithmetic would mis-order or drop the last write.
- **The head entry while its write is pending.** A premature pop would stop that entry forwarding before its acknowledge.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_DEPTH  = 8;
    localparam int SB_ADDR_W = 16;
    localparam int SB_DATA_W = 32;

    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } drain_state_e;
endpackage

// File: rtl/sb_fifo_store.sv
module sb_fifo_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int BEW   = DW / 8,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_addr,
    input  logic [DW-1:0]             push_data,
    input  logic [BEW-1:0]            push_be,
    input  logic                      pop,
    output logic [DEPTH-1:0][AW-1:0]  ent_addr,
    output logic [DEPTH-1:0][DW-1:0]  ent_data,
    output logic [DEPTH-1:0][BEW-1:0] ent_be,
    output logic [PW-1:0]             head_ptr,
    output logic [CW-1:0]             count
);
    logic [PW-1:0] tail_ptr;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
            ent_addr <= '0;
            ent_data <= '0;
            ent_be   <= '0;
        end else begin
            if (push) begin
                ent_addr[tail_ptr] <= push_addr;
                ent_data[tail_ptr] <= push_data;
                ent_be[tail_ptr]   <= push_be;
                tail_ptr           <= wrap_inc(tail_ptr);
            end
            if (pop) begin
                head_ptr <= wrap_inc(head_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R9: nothing is written into a full queue
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)));

    // R4: an entry is only removed when one exists
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

    // R10: occupancy follows the push and pop of the previous cycle
    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count == $past(count) + CW'($past(push)) - CW'($past(pop))));
endmodule

// File: rtl/sb_fwd_search.sv
module sb_fwd_search #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int BEW   = DW / 8,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]  ent_data,
    input  logic [DEPTH-1:0][BEW-1:0] ent_be,
    input  logic [PW-1:0]             head_ptr,
    input  logic [CW-1:0]             count,
    input  logic                      ld_valid,
    input  logic [AW-1:0]             ld_addr,
    input  logic [BEW-1:0]            ld_be,
    output logic                      ld_hit,
    output logic                      ld_replay,
    output logic [DW-1:0]             ld_data
);
    logic           found;
    logic [BEW-1:0] sel_be;
    logic [DW-1:0]  sel_data;
    logic           covers;

    // Walk from oldest to youngest; a later candidate overrides an earlier one
    always_comb begin
        found    = 1'b0;
        sel_be   = '0;
        sel_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PW-1:0] idx;
            idx = PW'((int'(head_ptr) + k) % DEPTH);
            if ((k < int'(count)) && (ent_addr[idx] == ld_addr) &&
                ((ent_be[idx] & ld_be) != '0)) begin
                found    = 1'b1;
                sel_be   = ent_be[idx];
                sel_data = ent_data[idx];
            end
        end
    end

    assign covers    = ((ld_be & ~sel_be) == '0);
    assign ld_hit    = ld_valid && found && covers;
    assign ld_replay = ld_valid && found && !covers;

    always_comb begin
        ld_data = '0;
        for (int b = 0; b < BEW; b++) begin
            if (ld_hit && ld_be[b]) begin
                ld_data[8*b +: 8] = sel_data[8*b +: 8];
            end
        end
    end

    // R7: a load is never both served and replayed
    assert_hit_replay_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_replay));

    // R8: an empty buffer forwards nothing
    assert_empty_no_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (!ld_hit && !ld_replay && ld_data == '0));
endmodule

// File: rtl/sb_drain_fsm.sv
module sb_drain_fsm
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_entry,
    input  logic wr_ack,
    output logic wr_req,
    output logic pop
);
    drain_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    // LAUNCH: IDLE->BUSY when an entry waits; RETIRE: BUSY->IDLE on acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: if (have_entry) state_d = DR_BUSY;
            DR_BUSY: if (wr_ack)     state_d = DR_IDLE;
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        wr_req = 1'b0;
        pop    = 1'b0;
        unique case (state_q)
            DR_IDLE: begin
                wr_req = 1'b0;
                pop    = 1'b0;
            end
            DR_BUSY: begin
                wr_req = 1'b1;
                pop    = wr_ack;
            end
            default: ;
        endcase
    end

    // R4: a request is held until acknowledged
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);

    // R4: one idle cycle follows every acknowledged write
    assert_gap_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !wr_req);

    // R3: a request always refers to an occupied entry
    assert_req_has_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> have_entry);
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
    parameter int DEPTH = sb_pkg::SB_DEPTH,
    parameter int AW    = sb_pkg::SB_ADDR_W,
    parameter int DW    = sb_pkg::SB_DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_valid,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    input  logic [DW/8-1:0] st_be,
    output logic            st_ready,
    output logic            st_retired,
    input  logic            ld_valid,
    input  logic [AW-1:0]   ld_addr,
    input  logic [DW/8-1:0] ld_be,
    output logic            ld_hit,
    output logic            ld_replay,
    output logic [DW-1:0]   ld_data,
    output logic            full,
    output logic            wr_req,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic [DW/8-1:0] wr_be,
    input  logic            wr_ack
);
    localparam int BEW = DW / 8;
    localparam int PW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][AW-1:0]  ent_addr;
    logic [DEPTH-1:0][DW-1:0]  ent_data;
    logic [DEPTH-1:0][BEW-1:0] ent_be;
    logic [PW-1:0]             head_ptr;
    logic [CW-1:0]             count;
    logic                      push;
    logic                      pop;

    assign full       = (count == CW'(DEPTH));
    assign st_ready   = !full;
    assign push       = st_valid && st_ready;
    assign st_retired = push;

    sb_fifo_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BEW(BEW), .PW(PW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .push_be   (st_be),
        .pop       (pop),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_be    (ent_be),
        .head_ptr  (head_ptr),
        .count     (count)
    );

    sb_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BEW(BEW), .PW(PW), .CW(CW)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_be    (ent_be),
        .head_ptr  (head_ptr),
        .count     (count),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_be     (ld_be),
        .ld_hit    (ld_hit),
        .ld_replay (ld_replay),
        .ld_data   (ld_data)
    );

    sb_drain_fsm u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .have_entry (count != '0),
        .wr_ack     (wr_ack),
        .wr_req     (wr_req),
        .pop        (pop)
    );

    assign wr_addr = ent_addr[head_ptr];
    assign wr_data = ent_data[head_ptr];
    assign wr_be   = ent_be[head_ptr];

    // R4: the offered write does not change while it waits
    assert_wr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> ($stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

    // R2: a store is retired only while there is room
    assert_retire_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_retired |-> (count < CW'(DEPTH)));
endmodule

// File: tb/sim_tso_store_buffer.sv
module sim_tso_store_buffer;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BEW = DW / 8;
    localparam int VW = AW + BEW + 2 + DW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            st_valid = 1'b0;
    logic [AW-1:0]   st_addr = '0;
    logic [DW-1:0]   st_data = '0;
    logic [BEW-1:0]  st_be = '0;
    logic            st_ready, st_retired;
    logic            ld_valid = 1'b0;
    logic [AW-1:0]   ld_addr = '0;
    logic [BEW-1:0]  ld_be = '0;
    logic            ld_hit, ld_replay;
    logic [DW-1:0]   ld_data;
    logic            full, wr_req;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;
    logic [BEW-1:0]  wr_be;
    logic            wr_ack = 1'b0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tso_store_buffer #(.DEPTH(8), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_ready(st_ready), .st_retired(st_retired),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
        .ld_hit(ld_hit), .ld_replay(ld_replay), .ld_data(ld_data),
        .full(full), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .wr_ack(wr_ack)
    );

    // Load vectors: {addr, be, exp_hit, exp_replay, exp_data}, buffer holding s0..s5
    localparam logic [VW-1:0] LD_TAB [10] = '{
        {16'h0010, 4'hF, 1'b1, 1'b0, 32'hAAAAAAAA},
        {16'h0020, 4'hF, 1'b1, 1'b0, 32'h22222222},
        {16'h0020, 4'h3, 1'b1, 1'b0, 32'h00002222},
        {16'h0030, 4'h3, 1'b1, 1'b0, 32'h00003333},
        {16'h0030, 4'hF, 1'b0, 1'b1, 32'h00000000},
        {16'h0030, 4'hC, 1'b0, 1'b0, 32'h00000000},
        {16'h0040, 4'h3, 1'b1, 1'b0, 32'h00004444},
        {16'h0040, 4'hC, 1'b1, 1'b0, 32'h55550000},
        {16'h0040, 4'hF, 1'b0, 1'b1, 32'h00000000},
        {16'h0050, 4'hF, 1'b0, 1'b0, 32'h00000000}
    };

    localparam logic [AW-1:0] DR_ADDR [8] = '{16'h20, 16'h10, 16'h30, 16'h40,
                                              16'h40, 16'h60, 16'h70, 16'h80};
    localparam logic [DW-1:0] DR_DATA [8] = '{32'h22222222, 32'hAAAAAAAA, 32'h33333333,
                                              32'h44444444, 32'h55555555, 32'h66666666,
                                              32'h77777777, 32'h88888888};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input logic [BEW-1:0] be);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        #1;
        chk("R2 retired", 64'(st_retired), 64'd1);
        tick();
        st_valid = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [AW-1:0] a, input logic [BEW-1:0] be,
                          input logic eh, input logic er, input logic [DW-1:0] ed);
        ld_valid = 1'b1; ld_addr = a; ld_be = be;
        #1;
        chk(req, {30'd0, ld_hit, ld_replay, ld_data}, {30'd0, eh, er, ed});
        ld_valid = 1'b0;
    endtask

    task automatic wait_req();
        for (int w = 0; w < 8 && !wr_req; w++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 full", 64'(full), 64'd0);
        chk("R1 st_ready", 64'(st_ready), 64'd1);
        chk("R1 wr_req", 64'(wr_req), 64'd0);
        lookup("R1 empty lookup", 16'h0010, 4'hF, 1'b0, 1'b0, 32'h0);

        // Fill with s0..s5, no acknowledge
        push_store(16'h0010, 32'h11111111, 4'hF);
        push_store(16'h0020, 32'h22222222, 4'hF);
        push_store(16'h0010, 32'hAAAAAAAA, 4'hF);
        push_store(16'h0030, 32'h33333333, 4'h3);
        push_store(16'h0040, 32'h44444444, 4'h3);
        push_store(16'h0040, 32'h55555555, 4'hC);
        chk("R4 req pending", 64'(wr_req), 64'd1);
        chk("R3 head addr", 64'(wr_addr), 64'h10);
        chk("R11 head data", 64'(wr_data), 64'h11111111);

        // Table walk: R5 youngest, R6 hit, R7 replay, R8 miss
        for (int i = 0; i < 10; i++) begin
            logic [VW-1:0] v;
            v = LD_TAB[i];
            lookup($sformatf("R5/R6/R7/R8 vec%0d", i), v[VW-1 -: AW], v[DW+2 +: BEW],
                   v[DW+1], v[DW], v[DW-1:0]);
        end

        // R8: store and load in the same cycle, store not visible
        st_valid = 1'b1; st_addr = 16'h0060; st_data = 32'h66666666; st_be = 4'hF;
        lookup("R8 same-cycle store", 16'h0060, 4'hF, 1'b0, 1'b0, 32'h0);
        chk("R2 retired s6", 64'(st_retired), 64'd1);
        tick();
        st_valid = 1'b0;
        push_store(16'h0070, 32'h77777777, 4'hF);
        chk("R9 full", 64'(full), 64'd1);
        chk("R9 st_ready", 64'(st_ready), 64'd0);

        // R9: refused while full even with acknowledge
        st_valid = 1'b1; st_addr = 16'h00EE; st_data = 32'hEEEEEEEE; st_be = 4'hF;
        wr_ack = 1'b1;
        #1;
        chk("R9 refused", 64'(st_retired), 64'd0);
        chk("R3 first drain", 64'(wr_addr), 64'h10);
        tick();
        st_valid = 1'b0; wr_ack = 1'b0;
        chk("R9 not full after pop", 64'(full), 64'd0);
        chk("R4 gap after ack", 64'(wr_req), 64'd0);
        lookup("R9 refused absent", 16'h00EE, 4'hF, 1'b0, 1'b0, 32'h0);
        lookup("R5 younger remains", 16'h0010, 4'hF, 1'b1, 1'b0, 32'hAAAAAAAA);

        // Drain in order (R3), hold check (R4), enqueue with drain (R10)
        for (int i = 0; i < 8; i++) begin
            wait_req();
            if (i == 0) begin
                tick();
                tick();
                chk("R4 hold req", 64'(wr_req), 64'd1);
                chk("R4 hold addr", 64'(wr_addr), 64'h20);
            end
            chk($sformatf("R3 drain addr %0d", i), 64'(wr_addr), 64'(DR_ADDR[i]));
            chk($sformatf("R3 drain data %0d", i), 64'(wr_data), 64'(DR_DATA[i]));
            wr_ack = 1'b1;
            if (i == 0) begin
                st_valid = 1'b1; st_addr = 16'h0080; st_data = 32'h88888888; st_be = 4'hF;
                #1;
                chk("R10 enqueue with drain", 64'(st_retired), 64'd1);
            end
            tick();
            wr_ack = 1'b0; st_valid = 1'b0;
        end
        tick();
        tick();
        chk("R10 emptied", 64'(wr_req), 64'd0);
        lookup("R10 nothing left", 16'h0080, 4'hF, 1'b0, 1'b0, 32'h0);

        // R4: acknowledge while idle is ignored
        wr_ack = 1'b1;
        tick();
        wr_ack = 1'b0;
        chk("R4 idle ack ignored", 64'(wr_req), 64'd0);

        // R11: pending head still forwards, gone after acknowledge
        push_store(16'h0090, 32'h99999999, 4'hF);
        tick();
        chk("R11 req raised", 64'(wr_req), 64'd1);
        chk("R4 idle ack no pop", 64'(wr_addr), 64'h90);
        lookup("R11 pending forwards", 16'h0090, 4'hF, 1'b1, 1'b0, 32'h99999999);
        wr_ack = 1'b1;
        tick();
        wr_ack = 1'b0;
        lookup("R11 gone after ack", 16'h0090, 4'hF, 1'b0, 1'b0, 32'h0);
        chk("R11 idle", 64'(wr_req), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule